// File: doc/BRIEF.md
# Bit-Configurable Input/Output Port with Interrupt Detection

This block is a general-purpose pin port of parameterised width with a simple register interface. Software sets the direction of each pin on its own. Output pins drive the value held in an output data register. Every pin is sampled through a synchronizer and a stability filter. The filtered level of every pin can be read back, whatever its direction.

Each pin that is configured as an input can raise an interrupt. A pin's trigger can be a level or an edge, in either positive logic (high level, rising edge) or negative logic (low level, falling edge). An edge event sets a sticky status bit, which software clears by writing a one to it. A level status bit follows the filtered pin level. The block has a single interrupt line, which is active while any status bit is set and has its enable set.

The register bus is a plain control interface with no back-pressure. A write takes effect on the clock edge where select and write are both high. A read returns its data on the cycle after that edge. The defaults are a 13-bit port and a two-stage synchronizer; a 12-bit port uses the same code.

Top module: `gpio_port`

## Requirements
- R1: After reset every pin is an input (pad_oe all zero), the output data register is zero, all interrupt enables are zero, all modes are level, all polarities are positive and irq is low.
- R2: A write to address 0 (direction, 1 = output) or to address 1 (output data) appears on pad_oe or pad_out in the cycle after the write edge.
- R3: A read of address 2 returns the filtered level of every pin. This holds for pins configured as outputs as well.
- R4: A pin value that lasts for only one clock is ignored. A value that lasts for two clocks or more is accepted as the new filtered level.
- R5: A pin change that is set up before clock edge 1 reaches the filtered level, an edge status bit and irq after edge 4, and not earlier.
- R6: In edge mode (address 4, bit = 1), a qualifying edge sets the status bit (address 6). The bit stays set until a write to address 6 with a one in that bit position. A write with a zero in that position leaves the bit unchanged.
- R7: In level mode (address 4, bit = 0), the status bit reads 1 while the filtered level matches the polarity (address 5, 1 = high, 0 = low), and 0 otherwise.
- R8: A pin configured as an output never sets its status bit, in either mode.
- R9: irq is the OR over all bits of status AND enable (address 3). A status bit whose enable is zero keeps irq low, but its status still reads back as 1.
- R10: A write to address 7 changes no register. A read of address 7 returns zero.
- R11: When a qualifying edge and a clearing write hit the same bit on the same edge, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, valid the cycle after the read edge |
| pad_in | input | WIDTH | Raw pin inputs |
| pad_oe | output | WIDTH | Per-pin output enable |
| pad_out | output | WIDTH | Per-pin output value |
| irq | output | 1 | Combined interrupt request |

## Verification
A register write is visible on the pads one edge after it is accepted, and read data is visible one edge after the read is accepted. A pin change needs four edges to reach the filtered level, the edge status and irq. Level status and irq follow the filtered level in the same cycle. The bench drives every input just after a falling edge and samples on falling edges. It counts rising edges explicitly wherever the exact latency matters: on the edge-4 boundary and on the edge where a set and a clear collide. Elsewhere it waits well past the four-edge window before it reads.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR  = 3'd0,
    RA_DOUT = 3'd1,
    RA_DIN  = 3'd2,
    RA_IEN  = 3'd3,
    RA_MODE = 3'd4,
    RA_POL  = 3'd5,
    RA_STAT = 3'd6,
    RA_NONE = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_in_qual.sv
`timescale 1ns/1ps
// Synchronizer chain followed by a two-sample stability filter.
module gpio_in_qual #(
  parameter int WIDTH       = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] level_q,
  output logic [WIDTH-1:0] rise_p,
  output logic [WIDTH-1:0] fall_p
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0][WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] cur, prev, stable, upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN-2:0], pin_raw};
  end

  assign cur    = chain_q[SYNC_STAGES-1];
  assign prev   = chain_q[SYNC_STAGES];
  assign stable = ~(cur ^ prev);
  assign upd    = stable & (cur ^ level_q);
  assign rise_p = upd & cur;
  assign fall_p = upd & ~cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= (level_q & ~upd) | (cur & upd);
  end
endmodule

// File: rtl/gpio_irq_cell.sv
`timescale 1ns/1ps
// One pin's interrupt detector: sticky edge flag or live level match.
module gpio_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic is_in,
  input  logic mode_edge,
  input  logic pol_pos,
  input  logic level,
  input  logic rise,
  input  logic fall,
  input  logic clr,
  output logic edge_flag,
  output logic stat
);
  logic hit;

  assign hit = is_in & (pol_pos ? rise : fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          edge_flag <= 1'b0;
    else if (!mode_edge) edge_flag <= 1'b0;
    else if (hit)        edge_flag <= 1'b1;
    else if (clr)        edge_flag <= 1'b0;
  end

  assign stat = mode_edge ? edge_flag : (is_in & (level == pol_pos));
endmodule

// File: rtl/gpio_regfile.sv
`timescale 1ns/1ps
// Configuration registers, clear strobes and registered read mux.
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  din,
  input  logic [WIDTH-1:0]  stat_view,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  dout_q,
  output logic [WIDTH-1:0]  ien_q,
  output logic [WIDTH-1:0]  mode_q,
  output logic [WIDTH-1:0]  pol_q,
  output logic [WIDTH-1:0]  stat_clr
);
  reg_addr_e        addr;
  logic             wr_en, rd_en;
  logic [WIDTH-1:0] rd_mux;

  assign addr  = reg_addr_e'(bus_addr);
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      ien_q  <= '0;
      mode_q <= '0;
      pol_q  <= '1;
    end else if (wr_en) begin
      case (addr)
        RA_DIR:  dir_q  <= bus_wdata;
        RA_DOUT: dout_q <= bus_wdata;
        RA_IEN:  ien_q  <= bus_wdata;
        RA_MODE: mode_q <= bus_wdata;
        RA_POL:  pol_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign stat_clr = (wr_en && addr == RA_STAT) ? bus_wdata : '0;

  always_comb begin
    case (addr)
      RA_DIR:  rd_mux = dir_q;
      RA_DOUT: rd_mux = dout_q;
      RA_DIN:  rd_mux = din;
      RA_IEN:  rd_mux = ien_q;
      RA_MODE: rd_mux = mode_q;
      RA_POL:  rd_mux = pol_q;
      RA_STAT: rd_mux = stat_view;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic              irq
);
  logic [WIDTH-1:0] level_q, rise_p, fall_p;
  logic [WIDTH-1:0] dir_q, dout_q, ien_q, mode_q, pol_q, stat_clr;
  logic [WIDTH-1:0] estat_vec, stat_view;

  gpio_in_qual #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin_raw(pad_in),
    .level_q(level_q), .rise_p(rise_p), .fall_p(fall_p)
  );

  gpio_regfile #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .din(level_q), .stat_view(stat_view),
    .dir_q(dir_q), .dout_q(dout_q), .ien_q(ien_q),
    .mode_q(mode_q), .pol_q(pol_q), .stat_clr(stat_clr)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    gpio_irq_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .is_in(~dir_q[i]), .mode_edge(mode_q[i]), .pol_pos(pol_q[i]),
      .level(level_q[i]), .rise(rise_p[i]), .fall(fall_p[i]),
      .clr(stat_clr[i]),
      .edge_flag(estat_vec[i]), .stat(stat_view[i])
    );
  end

  assign pad_oe  = dir_q;
  assign pad_out = dout_q;
  assign irq     = |(stat_view & ien_q);
endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pad_out,
  input logic              irq,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  ien_q,
  input logic [WIDTH-1:0]  mode_q,
  input logic [WIDTH-1:0]  estat_vec
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && ien_q == '0 && !irq));

  assert_oe_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == RA_DIR) |=> (pad_oe == $past(bus_wdata)));

  assert_out_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == RA_DOUT) |=> (pad_out == $past(bus_wdata)));

  assert_sticky_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(estat_vec) & ~estat_vec & $past(mode_q) & mode_q))
      |-> $past(bus_sel && bus_wr && bus_addr == RA_STAT));

  assert_output_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((estat_vec & ~$past(estat_vec) & $past(dir_q)) == '0));

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_oe(pad_oe),
  .pad_out(pad_out), .irq(irq), .dir_q(dir_q), .ien_q(ien_q),
  .mode_q(mode_q), .estat_vec(estat_vec)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
  localparam int W = 13;
  localparam logic [2:0] A_DIR = 3'd0, A_DOUT = 3'd1, A_DIN = 3'd2, A_IEN = 3'd3,
                         A_MODE = 3'd4, A_POL = 3'd5, A_STAT = 3'd6, A_RSV = 3'd7;
  // {mode_edge, pol_pos, pin_before, pin_after, expected_status}
  localparam logic [4:0] VEC [8] = '{5'b00010, 5'b00101, 5'b01011, 5'b01100,
                                     5'b10010, 5'b10101, 5'b11011, 5'b11100};

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_oe, pad_out;
  logic irq;
  int n_run = 0, n_fail = 0;
  logic [W-1:0] rv;

  always #4 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 irq", irq, 0);
    rd(A_IEN, rv);  chk("R1 ien", rv, 0);
    rd(A_MODE, rv); chk("R1 mode", rv, 0);
    rd(A_POL, rv);  chk("R1 pol", rv, 13'h1FFF);

    // Table walk on bit 0: R7 level and R6 edge behaviour, plus R9 irq
    wr(A_IEN, 13'h0001);
    foreach (VEC[k]) begin
      wr(A_MODE, {12'h000, VEC[k][4]});
      wr(A_POL, {12'hFFF, VEC[k][3]});
      pad_in[0] = VEC[k][2]; idle(8);
      wr(A_STAT, 13'h0001);
      pad_in[0] = VEC[k][1]; idle(8);
      rd(A_STAT, rv);
      chk($sformatf("R7/R6 vec%0d status", k), rv[0], VEC[k][0]);
      chk($sformatf("R9 vec%0d irq", k), irq, VEC[k][0]);
    end
    wr(A_IEN, 0); wr(A_MODE, 0); wr(A_POL, 13'h1FFF); pad_in = '0; idle(8);

    // R2 pad drive
    wr(A_DIR, 13'h000F);
    chk("R2 pad_oe", pad_oe, 13'h000F);
    wr(A_DOUT, 13'h01A5);
    chk("R2 pad_out", pad_out, 13'h01A5);

    // R3 input readback, including output pins
    pad_in = 13'h00AB; idle(8);
    rd(A_DIN, rv); chk("R3 din", rv, 13'h00AB);
    wr(A_DIR, 0); pad_in = '0; idle(8);

    // R4 glitch filter on bit 1, rising edge mode
    wr(A_MODE, 13'h0002); wr(A_IEN, 13'h0002); wr(A_STAT, 13'h1FFF);
    pad_in[1] = 1; @(negedge clk); pad_in[1] = 0; idle(8);
    rd(A_STAT, rv); chk("R4 one-clock pulse ignored", rv[1], 0);
    chk("R4 irq quiet", irq, 0);
    pad_in[1] = 1; idle(2); pad_in[1] = 0; idle(8);
    rd(A_STAT, rv); chk("R4 two-clock pulse taken", rv[1], 1);

    // R6 sticky and write-one-clear
    wr(A_STAT, 13'h1FFD);
    rd(A_STAT, rv); chk("R6 zero write keeps", rv[1], 1);
    wr(A_STAT, 13'h0002);
    rd(A_STAT, rv); chk("R6 one write clears", rv[1], 0);

    // R5 latency on bit 4
    wr(A_MODE, 13'h0010); wr(A_IEN, 13'h0010); wr(A_STAT, 13'h1FFF);
    pad_in[4] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R5 irq low after edge 3", irq, 0);
    @(posedge clk); @(negedge clk); chk("R5 irq high after edge 4", irq, 1);
    pad_in[4] = 0; idle(8); wr(A_STAT, 13'h1FFF);

    // R8 output pin cannot set status
    wr(A_DIR, 13'h0004); wr(A_MODE, 13'h0004); wr(A_IEN, 13'h0004);
    pad_in[2] = 1; idle(8); pad_in[2] = 0; idle(8); pad_in[2] = 1; idle(8);
    rd(A_STAT, rv); chk("R8 edge on output pin", rv[2], 0);
    wr(A_MODE, 0);
    rd(A_STAT, rv); chk("R8 level on output pin", rv[2], 0);
    chk("R8 irq", irq, 0);
    wr(A_DIR, 0); pad_in[2] = 0; idle(8);

    // R9 enable masking on bit 5
    wr(A_MODE, 13'h0020); wr(A_IEN, 0); wr(A_STAT, 13'h1FFF);
    pad_in[5] = 1; idle(8);
    rd(A_STAT, rv); chk("R9 status set while disabled", rv[5], 1);
    chk("R9 irq masked", irq, 0);
    wr(A_IEN, 13'h0020); chk("R9 irq after enable", irq, 1);
    wr(A_IEN, 0); wr(A_STAT, 13'h1FFF);

    // R10 reserved address
    wr(A_DIR, 13'h0003);
    wr(A_RSV, 13'h1FFF);
    rd(A_DIR, rv); chk("R10 dir untouched", rv, 13'h0003);
    rd(A_MODE, rv); chk("R10 mode untouched", rv, 13'h0020);
    rd(A_RSV, rv); chk("R10 reserved reads zero", rv, 0);
    wr(A_DIR, 0);

    // R11 set wins over same-edge clear, bit 3
    wr(A_MODE, 13'h0008); wr(A_STAT, 13'h1FFF); idle(2);
    pad_in[3] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = A_STAT; bus_wdata = 13'h0008;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    rd(A_STAT, rv); chk("R11 set beats clear", rv[3], 1);
    wr(A_STAT, 13'h0008);
    rd(A_STAT, rv); chk("R11 later clear works", rv[3], 0);

    finish_run();
  end
endmodule